// File: doc/BRIEF.md
# Widening SIMD Multiply-Accumulate Unit

This unit performs a packed, widening integer multiply-accumulate across a 128-bit vector. It takes one 64-bit half from each of two source vectors and splits that half into lanes of 8, 16 or 32 bits. It multiplies matching lanes to full double-width products. Each product is then added to, or subtracted from, the matching double-width lane of a 128-bit accumulator, which is the current value of the destination. The updated destination comes back two clock cycles after the operation is presented, marked by a one-cycle done pulse.

A 2-bit size code picks the lane width. A half-select bit chooses the low or high half of both sources. One select chooses between signed and unsigned operands, and another chooses between accumulating and subtracting. Accumulation wraps within each lane and never saturates. The one reserved size code is flagged at the output together with the done pulse, and the destination is handed back unchanged. A new operation may be presented on every cycle.

Top module: `wmac_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first operation completes, `done` is 0, `rsv_size` is 0 and `dst_out` is all zeros.
- R2: An operation presented with `op_valid`=1 at a rising edge produces exactly one `done` pulse, one cycle wide, at the second rising edge after it. Operations presented on consecutive cycles complete on consecutive cycles, in order. No `done` is produced without an operation.
- R3: Input lane width is 8 << `lane_size` (0: 8, 1: 16, 2: 32 bits). There are 64 / width lanes. Source lane i occupies bits [W*i +: W] of the selected half. Result lane i occupies bits [2W*i +: 2W] of `dst_out`, so lane 0 is in the least significant bits.
- R4: `upper_half`=0 takes bits 63:0 of both `mul_a` and `mul_b`; `upper_half`=1 takes bits 127:64 of both.
- R5: `is_unsigned`=1 treats lanes as unsigned; 0 treats them as two's complement. The full product is kept to 2W bits (for example 8-bit 0xFF times 0x02 gives 0xFFFE signed and 0x01FE unsigned).
- R6: `do_sub`=1 subtracts each product from its accumulator lane; `do_sub`=0 adds it.
- R7: Each lane's accumulation wraps modulo 2^(2W) without saturation, and no carry or borrow crosses into a neighbouring lane.
- R8: `lane_size`=3 is reserved. With that code, the completing `done` cycle shows `rsv_size`=1 and `dst_out` equal to the accumulator presented with the operation. For every other code, `rsv_size` is 0 on `done`.
- R9: `dst_out` and `rsv_size` hold their values in every cycle in which `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation presented this cycle |
| mul_a | input | 128 | First multiplicand source vector |
| mul_b | input | 128 | Second multiplicand source vector |
| acc_in | input | 128 | Current destination value used as accumulator |
| lane_size | input | 2 | Lane width code; 3 is reserved |
| upper_half | input | 1 | Selects the high 64-bit half of both sources |
| do_sub | input | 1 | Subtract products instead of adding them |
| is_unsigned | input | 1 | Treat lanes as unsigned |
| done | output | 1 | One-cycle pulse when a result is written back |
| dst_out | output | 128 | Updated destination vector |
| rsv_size | output | 1 | Completing operation used the reserved size code |

## Verification
Two behaviours can land in the same cycle. In one cycle, one operation's product can be registered while an earlier operation's accumulation is written back. Also, a reserved-size operation can retire right next to valid ones, and its pass-through must not pick up the neighbour's product. The bench provokes both by presenting three operations on consecutive cycles: a valid signed accumulate, a reserved-size operation, and an unsigned subtract. It then checks that `done` stays high for exactly three cycles and that each cycle carries its own expected vector and flag. A reference computed lane by lane in the bench decides each expected value.

// File: rtl/wmac_pkg.sv
package wmac_pkg;

   typedef enum logic [1:0] {
      LSZ_8   = 2'd0,
      LSZ_16  = 2'd1,
      LSZ_32  = 2'd2,
      LSZ_RSV = 2'd3
   } lane_size_e;

   typedef struct packed {
      logic       sub;
      logic       uns;
      lane_size_e size;
      logic       rsv;
   } mac_ctrl_t;

endpackage

// File: rtl/wmac_half_sel.sv
module wmac_half_sel #(
   parameter int VEC_W = 128
) (
   input  logic [VEC_W-1:0]   src_a,
   input  logic [VEC_W-1:0]   src_b,
   input  logic               upper,
   output logic [VEC_W/2-1:0] half_a,
   output logic [VEC_W/2-1:0] half_b
);
   localparam int HALF_W = VEC_W / 2;

   if (VEC_W % 2 != 0) begin : g_chk_even
      $error("wmac_half_sel: VEC_W must be even");
   end

   always_comb begin
      if (upper) begin
         half_a = src_a[VEC_W-1:HALF_W];
         half_b = src_b[VEC_W-1:HALF_W];
      end else begin
         half_a = src_a[HALF_W-1:0];
         half_b = src_b[HALF_W-1:0];
      end
   end
endmodule

// File: rtl/wmac_lane_mul.sv
module wmac_lane_mul
   import wmac_pkg::*;
#(
   parameter int HALF_W    = 64,
   parameter int BASE_W    = 8,
   parameter int NUM_SIZES = 3
) (
   input  logic [HALF_W-1:0]   half_a,
   input  logic [HALF_W-1:0]   half_b,
   input  logic                uns,
   input  lane_size_e          size,
   output logic [2*HALF_W-1:0] prod
);
   localparam int OUT_W = 2 * HALF_W;

   logic [NUM_SIZES-1:0][OUT_W-1:0] prod_by_size;

   for (genvar s = 0; s < NUM_SIZES; s++) begin : g_sz
      localparam int W = BASE_W << s;
      localparam int N = HALF_W / W;
      for (genvar l = 0; l < N; l++) begin : g_ln
         logic           ext_a, ext_b;
         logic [2*W-1:0] wide_a, wide_b;
         // sign or zero extension to 2W: the low 2W bits of a 2W x 2W
         // product equal the exact product for both interpretations
         assign ext_a  = ~uns & half_a[W*l + W - 1];
         assign ext_b  = ~uns & half_b[W*l + W - 1];
         assign wide_a = {{W{ext_a}}, half_a[W*l +: W]};
         assign wide_b = {{W{ext_b}}, half_b[W*l +: W]};
         assign prod_by_size[s][2*W*l +: 2*W] = wide_a * wide_b;
      end
   end

   always_comb begin
      prod = '0;
      for (int s = 0; s < NUM_SIZES; s++) begin
         if (int'(size) == s) prod = prod_by_size[s];
      end
   end
endmodule

// File: rtl/wmac_lane_acc.sv
module wmac_lane_acc
   import wmac_pkg::*;
#(
   parameter int VEC_W     = 128,
   parameter int BASE_W    = 8,
   parameter int NUM_SIZES = 3
) (
   input  logic [VEC_W-1:0] acc,
   input  logic [VEC_W-1:0] prod,
   input  logic             sub,
   input  lane_size_e       size,
   output logic [VEC_W-1:0] sum
);
   logic [NUM_SIZES-1:0][VEC_W-1:0] sum_by_size;

   for (genvar s = 0; s < NUM_SIZES; s++) begin : g_sz
      localparam int AW = 2 * (BASE_W << s);
      localparam int N  = VEC_W / AW;
      for (genvar l = 0; l < N; l++) begin : g_ln
         // lane-local add/sub: width AW keeps each carry inside the lane
         assign sum_by_size[s][AW*l +: AW] = sub ? (acc[AW*l +: AW] - prod[AW*l +: AW])
                                                 : (acc[AW*l +: AW] + prod[AW*l +: AW]);
      end
   end

   always_comb begin
      sum = acc;
      for (int s = 0; s < NUM_SIZES; s++) begin
         if (int'(size) == s) sum = sum_by_size[s];
      end
   end
endmodule

// File: rtl/wmac_unit.sv
module wmac_unit
   import wmac_pkg::*;
#(
   parameter int VEC_W     = 128,
   parameter int BASE_W    = 8,
   parameter int NUM_SIZES = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         op_valid,
   input  logic [127:0] mul_a,
   input  logic [127:0] mul_b,
   input  logic [127:0] acc_in,
   input  logic [1:0]   lane_size,
   input  logic         upper_half,
   input  logic         do_sub,
   input  logic         is_unsigned,
   output logic         done,
   output logic [127:0] dst_out,
   output logic         rsv_size
);
   localparam int HALF_W = VEC_W / 2;
   localparam int MAX_W  = BASE_W << (NUM_SIZES - 1);

   if (VEC_W != 128) begin : g_chk_vec
      $error("wmac_unit: port list is fixed at 128 bits");
   end
   if (NUM_SIZES < 1 || NUM_SIZES > 3) begin : g_chk_nsz
      $error("wmac_unit: NUM_SIZES must leave a reserved 2-bit code");
   end
   if (HALF_W % MAX_W != 0) begin : g_chk_div
      $error("wmac_unit: half vector must hold whole lanes of every size");
   end

   // ---------------- stage 0: decode and select ----------------
   mac_ctrl_t          ctrl_d;
   logic [HALF_W-1:0]  half_a, half_b;
   logic [VEC_W-1:0]   prod_d;

   always_comb begin
      ctrl_d.sub  = do_sub;
      ctrl_d.uns  = is_unsigned;
      ctrl_d.size = lane_size_e'(lane_size);
      ctrl_d.rsv  = (int'(lane_size) >= NUM_SIZES);
   end

   wmac_half_sel #(.VEC_W(VEC_W)) u_sel (
      .src_a  (mul_a),
      .src_b  (mul_b),
      .upper  (upper_half),
      .half_a (half_a),
      .half_b (half_b)
   );

   wmac_lane_mul #(.HALF_W(HALF_W), .BASE_W(BASE_W), .NUM_SIZES(NUM_SIZES)) u_mul (
      .half_a (half_a),
      .half_b (half_b),
      .uns    (ctrl_d.uns),
      .size   (ctrl_d.size),
      .prod   (prod_d)
   );

   // ---------------- stage 1: registered products ----------------
   logic             s1_valid;
   mac_ctrl_t        s1_ctrl;
   logic [VEC_W-1:0] s1_prod, s1_acc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_ctrl  <= '0;
         s1_prod  <= '0;
         s1_acc   <= '0;
      end else begin
         s1_valid <= op_valid;
         if (op_valid) begin
            s1_ctrl <= ctrl_d;
            s1_prod <= prod_d;
            s1_acc  <= acc_in;
         end
      end
   end

   AST_ACCEPT_TO_S1: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> s1_valid);  // R2

   // ---------------- stage 2: accumulate and write back ----------------
   logic [VEC_W-1:0] sum_d;

   wmac_lane_acc #(.VEC_W(VEC_W), .BASE_W(BASE_W), .NUM_SIZES(NUM_SIZES)) u_acc (
      .acc  (s1_acc),
      .prod (s1_prod),
      .sub  (s1_ctrl.sub),
      .size (s1_ctrl.size),
      .sum  (sum_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done     <= 1'b0;
         dst_out  <= '0;
         rsv_size <= 1'b0;
      end else begin
         done <= s1_valid;
         if (s1_valid) begin
            dst_out  <= s1_ctrl.rsv ? s1_acc : sum_d;
            rsv_size <= s1_ctrl.rsv;
         end
      end
   end

   AST_S1_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |=> done);  // R2
   AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_valid |=> !done);  // R2
   AST_RSV_PASSES_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rsv_size) |-> (dst_out == $past(acc_in, 2)));  // R8
   AST_RSV_FLAG_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rsv_size == ($past(lane_size, 2) == 2'b11)));  // R8
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(dst_out) && $stable(rsv_size)));  // R9
endmodule

// File: tb/wmac_unit_tb.sv
module wmac_unit_tb_top;
   logic         clk = 1'b0;
   logic         rst_n;
   logic         op_valid;
   logic [127:0] mul_a, mul_b, acc_in;
   logic [1:0]   lane_size;
   logic         upper_half, do_sub, is_unsigned;
   logic         done;
   logic [127:0] dst_out;
   logic         rsv_size;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   wmac_unit dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid),
      .mul_a(mul_a), .mul_b(mul_b), .acc_in(acc_in),
      .lane_size(lane_size), .upper_half(upper_half),
      .do_sub(do_sub), .is_unsigned(is_unsigned),
      .done(done), .dst_out(dst_out), .rsv_size(rsv_size)
   );

   task automatic check(string req, logic [127:0] act, logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [127:0] ref_mac(logic [127:0] a, logic [127:0] b,
                                            logic [127:0] acc, logic [1:0] sz,
                                            logic hi, logic sub, logic uns);
      logic [127:0] ha, hb, res, m1, m2, ea, eb, pr, al, r;
      int w, n;
      if (sz == 2'd3) return acc;
      w  = 8 << sz;
      n  = 64 / w;
      ha = hi ? (a >> 64) : {64'd0, a[63:0]};
      hb = hi ? (b >> 64) : {64'd0, b[63:0]};
      m1 = (128'd1 << w) - 128'd1;
      m2 = (128'd1 << (2 * w)) - 128'd1;
      res = '0;
      for (int l = 0; l < n; l++) begin
         ea = (ha >> (w * l)) & m1;
         eb = (hb >> (w * l)) & m1;
         if (!uns && ea[w-1]) ea = ea | ~m1;
         if (!uns && eb[w-1]) eb = eb | ~m1;
         pr = (ea * eb) & m2;
         al = (acc >> (2 * w * l)) & m2;
         r  = (sub ? (al - pr) : (al + pr)) & m2;
         res = res | (r << (2 * w * l));
      end
      return res;
   endfunction

   task automatic drive(logic [127:0] a, logic [127:0] b, logic [127:0] acc,
                        logic [1:0] sz, logic hi, logic sub, logic uns);
      op_valid = 1'b1; mul_a = a; mul_b = b; acc_in = acc;
      lane_size = sz; upper_half = hi; do_sub = sub; is_unsigned = uns;
   endtask

   task automatic idle();
      op_valid = 1'b0; mul_a = '1; mul_b = '1; acc_in = '1;
      lane_size = 2'd0; upper_half = 1'b0; do_sub = 1'b0; is_unsigned = 1'b0;
   endtask

   // one operation, result and flag checked against an expected value
   task automatic run_op(string req, logic [127:0] a, logic [127:0] b,
                         logic [127:0] acc, logic [1:0] sz, logic hi,
                         logic sub, logic uns, logic [127:0] exp);
      logic [127:0] held;
      @(negedge clk); drive(a, b, acc, sz, hi, sub, uns);
      @(negedge clk); idle();
      check({req, " R2 no done after one edge"}, {127'd0, done}, 128'd0);
      @(negedge clk);
      check({req, " R2 done after two edges"}, {127'd0, done}, 128'd1);
      check(req, dst_out, exp);
      check({req, " R8 flag"}, {127'd0, rsv_size}, {127'd0, sz == 2'd3});
      held = dst_out;
      @(negedge clk); acc_in = ~acc;
      check({req, " R2 single pulse"}, {127'd0, done}, 128'd0);
      check({req, " R9 hold"}, dst_out, held);
   endtask

   task automatic run_ref(string req, logic [127:0] a, logic [127:0] b,
                          logic [127:0] acc, logic [1:0] sz, logic hi,
                          logic sub, logic uns);
      run_op(req, a, b, acc, sz, hi, sub, uns, ref_mac(a, b, acc, sz, hi, sub, uns));
   endtask

   task automatic t_reset();
      rst_n = 1'b0; idle();
      repeat (3) @(negedge clk);
      check("R1 done in reset", {127'd0, done}, 128'd0);
      check("R1 result in reset", dst_out, 128'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 flag after reset", {127'd0, rsv_size}, 128'd0);
      check("R1 result after reset", dst_out, 128'd0);
   endtask

   task automatic t_layout();
      // 32-bit lanes: lane0 3*5=15 in bits 63:0, lane1 7*2=14 in bits 127:64
      run_op("R3 32-bit lane placement", {64'd0, 32'd7, 32'd3}, {64'd0, 32'd2, 32'd5},
             128'd0, 2'd2, 1'b0, 1'b0, 1'b1, {64'd14, 64'd15});
      // 16-bit lanes: lane i value i+1 times 3 lands in 32-bit lane i
      run_op("R3 16-bit lane placement", {64'd0, 16'd4, 16'd3, 16'd2, 16'd1},
             {64'd0, 16'd3, 16'd3, 16'd3, 16'd3}, 128'd0, 2'd1, 1'b0, 1'b0, 1'b1,
             {32'd12, 32'd9, 32'd6, 32'd3});
      run_ref("R3 8-bit lanes", 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
              128'h1111_2222_3333_4444_8081_7F7E_0102_F0F1,
              128'h0F0E_0D0C_0B0A_0908_0706_0504_0302_0100, 2'd0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_part();
      // low halves 2*3, high halves 10*10
      run_op("R4 lower half", {64'd10, 64'd2}, {64'd10, 64'd3}, 128'd0, 2'd2,
             1'b0, 1'b0, 1'b1, {64'd0, 64'd6});
      run_op("R4 upper half", {64'd10, 64'd2}, {64'd10, 64'd3}, 128'd0, 2'd2,
             1'b1, 1'b0, 1'b1, {64'd0, 64'd100});
      run_ref("R4 upper half 16-bit", 128'h8000_7FFF_1234_ABCD_0000_0000_0000_0000,
              128'hFFFF_0002_4321_0003_FFFF_FFFF_FFFF_FFFF, 128'h5, 2'd1, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_sign();
      run_op("R5 signed 8-bit", {120'd0, 8'hFF}, {120'd0, 8'h02}, 128'd0, 2'd0,
             1'b0, 1'b0, 1'b0, {112'd0, 16'hFFFE});
      run_op("R5 unsigned 8-bit", {120'd0, 8'hFF}, {120'd0, 8'h02}, 128'd0, 2'd0,
             1'b0, 1'b0, 1'b1, {112'd0, 16'h01FE});
      run_ref("R5 signed 32-bit extremes", {64'd0, 32'h8000_0000, 32'h8000_0000},
              {64'd0, 32'h7FFF_FFFF, 32'h8000_0000}, 128'd0, 2'd2, 1'b0, 1'b0, 1'b0);
      run_ref("R5 unsigned 32-bit extremes", {64'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
              {64'd0, 32'hFFFF_FFFF, 32'h0000_0002}, 128'd0, 2'd2, 1'b0, 1'b0, 1'b1);
   endtask

   task automatic t_sub();
      run_op("R6 subtract 32-bit", {64'd0, 32'd0, 32'd2}, {64'd0, 32'd0, 32'd3},
             {64'd50, 64'd100}, 2'd2, 1'b0, 1'b1, 1'b1, {64'd50, 64'd94});
      run_ref("R6 subtract 16-bit signed", 128'h0, 128'hAAAA_5555_8000_7FFF_FFFF_0001_8000_1234,
              128'h0123_4567_89AB_CDEF_0011_2233_4455_6677, 2'd1, 1'b0, 1'b1, 1'b0);
   endtask

   task automatic t_wrap();
      // lane0 all ones + 1 wraps to 0, lane1 untouched
      run_op("R7 add wraps in lane", {64'd0, 32'd0, 32'd1}, {64'd0, 32'd0, 32'd1},
             {64'd7, 64'hFFFF_FFFF_FFFF_FFFF}, 2'd2, 1'b0, 1'b0, 1'b1, {64'd7, 64'd0});
      // 8-bit: 0 - 1 in 16-bit lane0 gives FFFF, lane1 keeps 0x0005
      run_op("R7 sub borrow stays in lane", {120'd0, 8'd1}, {120'd0, 8'd1},
             {96'd0, 16'h0005, 16'h0000}, 2'd0, 1'b0, 1'b1, 1'b1,
             {96'd0, 16'h0005, 16'hFFFF});
   endtask

   task automatic t_reserved();
      run_op("R8 reserved passes accumulator", '1, '1, 128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555,
             2'd3, 1'b1, 1'b1, 1'b0, 128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555);
   endtask

   task automatic t_back_to_back();
      logic [127:0] e0, e1, e2, a0, b0, c0;
      a0 = 128'h0102_0304_0506_0708_F1F2_F3F4_F5F6_F7F8;
      b0 = 128'h7F80_9091_A0A1_B0B1_0F0E_0D0C_0B0A_0908;
      c0 = 128'h1357_9BDF_0246_8ACE_FFFF_0000_AAAA_5555;
      e0 = ref_mac(a0, b0, c0, 2'd0, 1'b0, 1'b0, 1'b0);
      e1 = c0 ^ 128'h1;
      e2 = ref_mac(b0, a0, c0, 2'd1, 1'b1, 1'b1, 1'b1);
      @(negedge clk); drive(a0, b0, c0, 2'd0, 1'b0, 1'b0, 1'b0);
      @(negedge clk); drive(a0, b0, e1, 2'd3, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      check("R2 back-to-back op0 done", {127'd0, done}, 128'd1);
      check("R3 back-to-back op0 value", dst_out, e0);
      check("R8 back-to-back op0 flag", {127'd0, rsv_size}, 128'd0);
      drive(b0, a0, c0, 2'd1, 1'b1, 1'b1, 1'b1);
      @(negedge clk); idle();
      check("R2 back-to-back op1 done", {127'd0, done}, 128'd1);
      check("R8 back-to-back reserved value", dst_out, e1);
      check("R8 back-to-back reserved flag", {127'd0, rsv_size}, 128'd1);
      @(negedge clk);
      check("R2 back-to-back op2 done", {127'd0, done}, 128'd1);
      check("R6 back-to-back op2 value", dst_out, e2);
      check("R8 back-to-back op2 flag", {127'd0, rsv_size}, 128'd0);
      @(negedge clk);
      check("R2 stream ends", {127'd0, done}, 128'd0);
      check("R9 hold after stream", dst_out, e2);
   endtask

   task automatic t_sweep();
      logic [127:0] a, b, c;
      a = 128'h9E37_79B9_7F4A_7C15_F39C_C060_5CED_C834;
      b = 128'h2545_F491_4F6C_DD1D_B5AD_4ECE_DA1C_E2A9;
      c = 128'h6A09_E667_F3BC_C908_BB67_AE85_84CA_A73B;
      for (int i = 0; i < 24; i++) begin
         run_ref("R7 sweep", a, b, c, 2'(i % 3), 1'(i / 3), 1'(i / 6), 1'(i / 12));
         a = {a[126:0], a[127] ^ a[100]} ^ b;
         b = {b[0], b[127:1]} + c;
         c = c ^ {a[63:0], b[127:64]};
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog R2 actual=hung expected=complete");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_layout();
      t_part();
      t_sign();
      t_sub();
      t_wrap();
      t_reserved();
      t_back_to_back();
      t_sweep();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule